// File: doc/BRIEF.md
# Segment-Spread Grayscale PWM Generator

This block drives one channel output whose brightness is set by a grayscale value. Instead of emitting one long pulse per display period, it breaks the on-time into 128 short pulses, one per equal segment of the period. This raises the output PWM rate by a factor of 128 compared with a single-pulse scheme, for the same grayscale clock. A 16-bit period counter runs on the grayscale clock and restarts by itself at the end of every period. The period length is 2^N clocks, where the depth N is picked from 9 to 16.

Grayscale values are written into a holding register at any time. The holding value is moved into the active register only at the moment the counter wraps. The depth selection is sampled at that same moment. As a result, a period always completes with the value and depth it started with.

Within each segment the output goes high at the segment start for a base number of clocks, taken from the upper grayscale bits. The seven low bits decide which segments receive one extra clock. Those segments are picked in bit-reversed segment order, so the leftover clocks are scattered evenly over the period.

Top module: `esPwmGen`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `pwmOut` is 0. Reset clears both the holding and active values, sets the counter to the first clock of a period, and sets the depth to N = 9.
- R2: The depth is N = 9 + `depthSel`, where `depthSel` is 3 bits and unsigned. A period lasts exactly 2^N clocks, and the output pattern repeats every period with no outside action.
- R3: A change of `depthSel` takes effect only at the next period wrap. The period in progress keeps its old length.
- R4: When `gsWrEn` is high at a rising edge, `gsWrData` is captured into the holding register. The active value takes the holding value only at a period wrap, so the period in progress is not affected by the write.
- R5: The number of clocks per period with `pwmOut` high equals the low N bits of the active value. Bits at positions N and above are ignored.
- R6: An active value whose low N bits are zero keeps `pwmOut` low for the whole period.
- R7: The period is made of 128 segments of 2^(N-7) clocks each. In segment s, `pwmOut` is high for the first B clocks, where B is bits [N-1:7] of the value. It is also high for clock number B of that segment when the 7-bit bit-reversal of s is less than bits [6:0] of the value. The output depends only on the current counter position, so a value of 1 gives a single high clock at the first clock of the period. A value of 64 gives pulses in even segments only.
- R8: Any nonzero value that is a multiple of 128 gives exactly 128 separate pulses per period. The pulse rate is therefore the clock rate times 128 divided by 2^N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale clock |
| rstN | input | 1 | Asynchronous reset, active low |
| depthSel | input | 3 | Depth select, N = 9 + value, sampled at wrap |
| gsWrEn | input | 1 | Write strobe for the holding register |
| gsWrData | input | 16 | Grayscale value to hold |
| pwmOut | output | 1 | Channel on/off output |

## Verification
`pwmOut` is a combinational function of the registered counter and the active value. Its level therefore belongs to the clock slot in which the counter holds a given position. A write or a depth change shows up starting with the first clock slot of the period that follows the next wrap.

The bench drives inputs and samples `pwmOut` on falling edges. It keeps its own count of the position within the period, and it moves to the new depth only when that count wraps. This lets each measurement line up exactly with a period start. Each measurement then yields, from one full period, the total high clocks, the number of pulses and the slots of the first two rising edges.

// File: rtl/es_pwm_pkg.sv
package es_pwm_pkg;
  localparam int GS_W       = 16;                 // period counter / value width
  localparam int SEG_BITS   = 7;                  // log2 of segment count
  localparam int MIN_DEPTH  = 9;                  // smallest selectable N
  localparam int CODE_W     = 3;                  // depth select width
  localparam int SHIFT_W    = $clog2(GS_W - SEG_BITS + 1);
  localparam int SEGMENTS   = 1 << SEG_BITS;

  // Strobes and timing handed from control to datapath
  typedef struct packed {
    logic                load;     // last clock of period: transfer holding value
    logic [GS_W-1:0]     phase;    // position within the period
    logic [SHIFT_W-1:0]  posBits;  // N - SEG_BITS: log2 of segment length
  } ctrl_strobe_t;
endpackage

// File: rtl/esPwmCtrl.sv
module esPwmCtrl
  import es_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] depthSel,
  output ctrl_strobe_t      strb
);
  localparam logic [GS_W-1:0]    ALL_ONES   = '1;
  localparam logic [SHIFT_W-1:0] RESET_BITS = SHIFT_W'(MIN_DEPTH - SEG_BITS);
  localparam logic [SHIFT_W-1:0] MAX_BITS   = SHIFT_W'(GS_W - SEG_BITS);

  logic [GS_W-1:0]    cntQ;
  logic [SHIFT_W-1:0] posBitsQ;
  logic [SHIFT_W:0]   depthN;
  logic [GS_W-1:0]    periodMask;
  logic               wrap;
  logic [SHIFT_W-1:0] nextPosBits;

  always_comb begin
    depthN      = {1'b0, posBitsQ} + (SHIFT_W+1)'(SEG_BITS);
    periodMask  = ALL_ONES >> ((SHIFT_W+1)'(GS_W) - depthN);
    wrap        = (cntQ == periodMask);
    nextPosBits = RESET_BITS + SHIFT_W'(depthSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      posBitsQ <= RESET_BITS;
    end else if (wrap) begin
      cntQ     <= '0;
      posBitsQ <= nextPosBits;
    end else begin
      cntQ     <= cntQ + 1'b1;
    end
  end

  assign strb.load    = wrap;
  assign strb.phase   = cntQ;
  assign strb.posBits = posBitsQ;

  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= periodMask);
  assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (cntQ == '0));
  assert_depth_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> $stable(posBitsQ));
  assert_depth_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (posBitsQ >= RESET_BITS) && (posBitsQ <= MAX_BITS));
endmodule

// File: rtl/esPwmData.sv
module esPwmData
  import es_pwm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            gsWrEn,
  input  logic [GS_W-1:0] gsWrData,
  input  ctrl_strobe_t    strb,
  output logic            pwmOut
);
  localparam logic [GS_W-1:0] ALL_ONES = '1;

  logic [GS_W-1:0]     shadowQ;
  logic [GS_W-1:0]     activeQ;
  logic [GS_W-1:0]     lenMask;
  logic [GS_W-1:0]     slotPos;
  logic [GS_W-1:0]     baseOn;
  logic [SEG_BITS-1:0] segIdx;
  logic [SEG_BITS-1:0] slotRank;
  logic [SEG_BITS-1:0] extraCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
      activeQ <= '0;
    end else begin
      if (gsWrEn)    shadowQ <= gsWrData;
      if (strb.load) activeQ <= shadowQ;
    end
  end

  always_comb begin
    lenMask  = ~(ALL_ONES << strb.posBits);
    slotPos  = strb.phase & lenMask;
    segIdx   = SEG_BITS'(strb.phase >> strb.posBits);
    baseOn   = (activeQ >> SEG_BITS) & lenMask;
    extraCnt = activeQ[SEG_BITS-1:0];
  end

  // Bit-reversed segment rank spreads the extra clocks evenly
  for (genvar b = 0; b < SEG_BITS; b++) begin : g_rev
    assign slotRank[b] = segIdx[SEG_BITS-1-b];
  end

  assign pwmOut = (slotPos < baseOn) ||
                  ((slotPos == baseOn) && (slotRank < extraCnt));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    gsWrEn |=> (shadowQ == $past(gsWrData)));
  assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(activeQ));
  assert_active_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (activeQ == $past(shadowQ)));
  assert_zero_dark_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((baseOn == '0) && (extraCnt == '0)) |-> !pwmOut);
endmodule

// File: rtl/esPwmGen.sv
module esPwmGen
  import es_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] depthSel,
  input  logic              gsWrEn,
  input  logic [GS_W-1:0]   gsWrData,
  output logic              pwmOut
);
  ctrl_strobe_t strb;

  esPwmCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .depthSel (depthSel),
    .strb     (strb)
  );

  esPwmData i_data (
    .clk      (clk),
    .rstN     (rstN),
    .gsWrEn   (gsWrEn),
    .gsWrData (gsWrData),
    .strb     (strb),
    .pwmOut   (pwmOut)
  );
endmodule

// File: tb/test_esPwmGen.sv
module test_esPwmGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  depthSel = 3'd0;
  logic        gsWrEn = 1'b0;
  logic [15:0] gsWrData = 16'd0;
  logic        pwmOut;

  int checks = 0;
  int errors = 0;
  int pos = 0;      // bench-side position within period
  int curN = 9;     // bench-side active depth

  esPwmGen i_esPwmGen (
    .clk(clk), .rstN(rstN), .depthSel(depthSel),
    .gsWrEn(gsWrEn), .gsWrData(gsWrData), .pwmOut(pwmOut)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pos++;
    if (pos == (1 << curN)) begin
      pos  = 0;
      curN = 9 + int'(depthSel);
    end
  endtask

  task automatic toStart();
    while (pos != 0) step();
  endtask

  task automatic measure(output int onCnt, output int rises,
                         output int firstRise, output int secondRise);
    int len;
    logic prev;
    toStart();
    len = 1 << curN;
    onCnt = 0; rises = 0; firstRise = -1; secondRise = -1; prev = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (pwmOut) onCnt++;
      if (pwmOut && !prev) begin
        rises++;
        if (firstRise < 0) firstRise = i;
        else if (secondRise < 0) secondRise = i;
      end
      prev = pwmOut;
      step();
    end
  endtask

  task automatic writeVal(int v);
    if (pos == (1 << curN) - 1) step();
    gsWrData = 16'(v);
    gsWrEn   = 1'b1;
    step();
    gsWrEn   = 1'b0;
  endtask

  task automatic setVal(int v);
    writeVal(v);
    toStart();
  endtask

  task automatic testReset();
    int o, r, f, s;
    chk("R1 out during reset", int'(pwmOut), 0);
    @(negedge clk); rstN = 1'b1; pos = 0; curN = 9;
    chk("R1 out after reset", int'(pwmOut), 0);
    measure(o, r, f, s);
    chk("R6 zero value on-clocks", o, 0);
  endtask

  task automatic testBuffer();
    int o, r, f, s;
    int rest = 0;
    repeat (100) step();
    writeVal(300);
    while (pos != 0) begin
      if (pwmOut) rest++;
      step();
    end
    chk("R4 current period untouched", rest, 0);
    measure(o, r, f, s);
    chk("R4 R5 value 300 on-clocks", o, 300);
    chk("R7 value 300 first rise", f, 0);
    measure(o, r, f, s);
    chk("R2 repeat value 300 on-clocks", o, 300);
  endtask

  task automatic testSpread();
    int o, r, f, s;
    setVal(1);
    measure(o, r, f, s);
    chk("R7 value 1 on-clocks", o, 1);
    chk("R7 value 1 first slot", f, 0);
    setVal(64);
    measure(o, r, f, s);
    chk("R7 value 64 pulses", r, 64);
    chk("R7 value 64 second rise slot", s, 8);
    setVal(128);
    measure(o, r, f, s);
    chk("R8 value 128 pulses", r, 128);
    chk("R8 value 128 on-clocks", o, 128);
  endtask

  task automatic testWidth();
    int o, r, f, s;
    setVal(16'h1234);
    measure(o, r, f, s);
    chk("R5 upper bits ignored", o, 52);
    setVal(511);
    measure(o, r, f, s);
    chk("R5 full scale N=9", o, 511);
    setVal(0);
    measure(o, r, f, s);
    chk("R6 zero after nonzero", o, 0);
  endtask

  task automatic testDepthChange();
    int o, r, f, s;
    setVal(1);
    repeat (100) step();
    depthSel = 3'd1;
    toStart();
    chk("R3 old period length kept", int'(pwmOut), 1);
    measure(o, r, f, s);
    chk("R2 N=10 single pulse", r, 1);
    chk("R2 N=10 on-clocks", o, 1);
    chk("R2 N=10 next period start", int'(pwmOut), 1);
  endtask

  task automatic testWide();
    int o, r, f, s;
    depthSel = 3'd3;
    setVal(2048);
    measure(o, r, f, s);
    chk("R8 N=12 pulses", r, 128);
    chk("R5 N=12 on-clocks", o, 2048);
    depthSel = 3'd7;
    setVal(65535);
    measure(o, r, f, s);
    chk("R5 N=16 full scale", o, 65535);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testBuffer();
    testSpread();
    testWidth();
    testDepthChange();
    testWide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule